// File: doc/BRIEF.md
# Iterative Odd-Sum Squarer

This unit squares an unsigned N-bit operand without a multiplier. It uses the identity that each perfect square is the one before it plus the next odd integer. After a start request it clears a running sum. It then adds 1, 3, 5, 7 and so on, one odd term per clock, until it has added as many terms as the operand's value. The sum is then the square.

A client waits for `ready`, then raises `start` for one cycle with the operand on `operand`. The unit copies the operand on the accepting edge, and from then on the input may change freely. When the work is complete, `done` pulses for one cycle with the 2N-bit square on `result`. The square stays on `result` until the next start is accepted. One request runs at a time.

The datapath holds a remaining-term counter, an odd-term register, a 2N-bit accumulator and two instances of a generic adder. There is no multiplier. The unit requires N of 2 or more.

Top module: `odd_sum_squarer`

## Requirements
- R1: Reset is synchronous and active low. On any rising edge with `rst_n` low, the unit returns to idle. In the following cycle `ready` is 1, `done` is 0 and `result` is 0. This also holds when reset arrives during a computation.
- R2: A start is accepted only on an edge where `ready` and `start` are both 1. The operand is captured on that edge, and `ready` is 0 in the cycle that follows.
- R3: `result` is 2N bits wide and equals the square of the captured operand, including the largest operand (255 gives 65025 for N = 8).
- R4: For an operand n of 1 or more, the unit accumulates on each of the n rising edges that follow the accepting edge. `done` is 1 exactly in the cycle after the n-th of those edges, and 0 in every cycle before it.
- R5: For an operand of 0, `done` is 1 in the cycle directly after the accepting edge, with `result` equal to 0.
- R6: `done` is high for a single cycle. `ready` is 1 in the cycle after `done`, and `ready` and `done` are never 1 together.
- R7: While the unit is busy (`ready` = 0), changes on `operand` and a held `start` have no effect on the result or on the timing.
- R8: From the `done` cycle until the next accepted start, `result` holds the last square unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a squaring, taken only while ready |
| operand | input | N | Unsigned value to square, captured on acceptance |
| ready | output | 1 | Unit is idle and will accept a start |
| done | output | 1 | One-cycle pulse marking a valid square |
| result | output | 2N | Square of the captured operand |

## Verification
The bench runs several operand values, and each one separates a different kind of fault:
- Operands 0, 1, 2 and 3 tell the zero shortcut apart from the one-term and two-term paths, and expose an off-by-one in the term count or in the first odd addend.
- The largest operand, and operands near 128, show any truncation of the odd-term register or the accumulator.
- A run of pseudo-random operands checks timing that scales with the value.
- One pass scrambles the operand and another holds start high while the unit is busy; together they show that the captured copy, not the live input, drives the work.
- A reset issued in the middle of a computation shows that the unit returns cleanly to idle.

// File: rtl/sq_pkg.sv
// Shared types for the odd-sum squarer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sq_pkg;

    // Controller phases: waiting, adding odd terms, presenting the square.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIN  = 2'd2
    } sq_state_t;

endpackage

// File: rtl/sq_adder.sv
// Generic unsigned adder; the sum wraps at W bits.
// Assumes callers size the operands so that no wrap happens in use.
module sq_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);

    // Plain combinational addition.
    always_comb begin
        sum = a + b;
    end

endmodule

// File: rtl/sq_ctrl.sv
// Sequencer for the squarer: accepts a request, counts the remaining odd
// terms and raises Moore-style ready/done outputs.
// Assumes operand is only sampled on the accepting edge.
module sq_ctrl
    import sq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] operand,
    output logic         ready,
    output logic         done,
    output logic         load,
    output logic         step
);

    localparam logic [N-1:0] ONE = N'(1);

    sq_state_t    state;
    logic [N-1:0] left;

    // Moore outputs and datapath strobes decoded from the phase.
    always_comb begin
        ready = (state == SQ_IDLE);
        done  = (state == SQ_FIN);
        load  = (state == SQ_IDLE) && start;
        step  = (state == SQ_RUN);
    end

    // Phase register and remaining-term counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            left  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        left  <= operand;
                        state <= (operand == '0) ? SQ_FIN : SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    left <= left - ONE;
                    if (left == ONE) begin
                        state <= SQ_FIN;
                    end
                end
                SQ_FIN: begin
                    state <= SQ_IDLE;
                end
                default: begin
                    state <= SQ_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/sq_datapath.sv
// Odd-term register and accumulator. On load both restart (sum 0, odd 1);
// on step the odd term is added to the sum and the odd term grows by two.
// Assumes N >= 2 so the odd register (N+1 bits) is narrower than the sum.
module sq_datapath #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    output logic [2*N-1:0] acc
);

    localparam int AW = 2 * N;
    localparam int OW = N + 1;

    logic [OW-1:0] odd;
    logic [OW-1:0] odd_next;
    logic [AW-1:0] odd_wide;
    logic [AW-1:0] acc_next;
    logic [OW-1:0] two;

    // Constant addend and the widened odd term.
    always_comb begin
        two      = {{(OW-2){1'b0}}, 2'b10};
        odd_wide = {{(AW-OW){1'b0}}, odd};
    end

    sq_adder #(.W(AW)) u_sum_add (
        .a   (acc),
        .b   (odd_wide),
        .sum (acc_next)
    );

    sq_adder #(.W(OW)) u_odd_add (
        .a   (odd),
        .b   (two),
        .sum (odd_next)
    );

    // Accumulator and odd-term registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            odd <= '0;
        end else if (load) begin
            acc <= '0;
            odd <= {{(OW-1){1'b0}}, 1'b1};
        end else if (step) begin
            acc <= acc_next;
            odd <= odd_next;
        end
    end

endmodule

// File: rtl/odd_sum_squarer.sv
// Top of the odd-sum squarer: a sequencer plus an add-only datapath.
// The square of operand n appears after n accumulation cycles.
// Assumes N >= 2 and a single request in flight.
module odd_sum_squarer #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   operand,
    output logic           ready,
    output logic           done,
    output logic [2*N-1:0] result
);

    logic load;
    logic step;

    sq_ctrl #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .operand (operand),
        .ready   (ready),
        .done    (done),
        .load    (load),
        .step    (step)
    );

    sq_datapath #(.N(N)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .acc   (result)
    );

endmodule

// File: rtl/sq_chk.sv
// Protocol checker for the squarer, attached by bind.
// Assumes it observes the top-level ports only.
module sq_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [N-1:0]   operand,
    input logic           ready,
    input logic           done,
    input logic [2*N-1:0] result
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (ready && !done && result == '0));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> !ready);

    // R4
    nonzero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && operand != '0) |=> !done);

    // R5
    zero_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && operand == '0) |=> (done && result == '0));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready));

    // R6
    ready_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && done));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> $stable(result));

endmodule

bind odd_sum_squarer sq_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .operand (operand),
    .ready   (ready),
    .done    (done),
    .result  (result)
);

// File: tb/sim_odd_sum_squarer.sv
module sim_odd_sum_squarer;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   operand = '0;
    logic           ready;
    logic           done;
    logic [2*N-1:0] result;

    always #10 clk = ~clk;

    odd_sum_squarer #(.N(N)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .operand (operand),
        .ready   (ready),
        .done    (done),
        .result  (result)
    );

    int     n_cmp = 0;
    int     n_bad = 0;
    bit     finished = 0;
    string  phase = "";

    // Behavioural reference: cycles left, pending done, expected square.
    int     m_todo = 0;
    bit     m_done = 0;
    longint m_exp = 0;
    int     m_n = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_todo = 0;
            m_done = 0;
            m_exp  = 0;
        end else if (m_done) begin
            m_done = 0;
        end else if (m_todo > 0) begin
            m_todo = m_todo - 1;
            if (m_todo == 0) m_done = 1;
        end else if (start) begin
            m_n    = int'(operand);
            m_exp  = longint'(m_n) * longint'(m_n);
            m_todo = m_n;
            if (m_n == 0) m_done = 1;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, phase, act, exp);
        end
    endtask

    // Compare against the reference on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_ready;
            exp_ready = (m_todo == 0) && !m_done;
            chk("R2 ready", longint'(ready), longint'(exp_ready));
            chk("R4/R6 done", longint'(done), longint'(m_done));
            if (m_done)
                chk((m_n == 0) ? "R5 result" : "R3 result", longint'(result), m_exp);
            else if (exp_ready)
                chk("R8 result held", longint'(result), m_exp);
        end
    end

    task automatic run_op(input int v, input bit scramble, input bit hold);
        @(negedge clk);
        while (!ready) @(negedge clk);
        start   = 1'b1;
        operand = N'(v);
        @(negedge clk);
        if (!hold) start = 1'b0;
        while (!done) begin
            @(negedge clk);
            if (scramble) operand = N'($urandom);
        end
        start = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL R4 watchdog actual=busy expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready", longint'(ready), 1);
        chk("R1 done", longint'(done), 0);
        chk("R1 result", longint'(result), 0);
        rst_n = 1'b1;

        phase = "basic";
        run_op(0, 0, 0);
        run_op(1, 0, 0);
        run_op(2, 0, 0);
        run_op(3, 0, 0);
        run_op(0, 0, 0);
        run_op(7, 0, 0);
        repeat (4) @(negedge clk);

        phase = "wide";
        run_op(255, 0, 0);
        run_op(128, 0, 0);
        run_op(127, 0, 0);
        run_op(254, 0, 0);

        phase = "R7 scramble";
        run_op(13, 1, 0);
        run_op(200, 1, 0);
        phase = "R7 held start";
        run_op(9, 0, 1);
        run_op(0, 0, 1);

        phase = "random";
        for (int i = 0; i < 30; i++) run_op(int'($urandom_range(0, 60)), 0, 0);

        phase = "R1 mid-run reset";
        @(negedge clk);
        while (!ready) @(negedge clk);
        start = 1'b1;
        operand = N'(150);
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 ready", longint'(ready), 1);
        chk("R1 done", longint'(done), 0);
        chk("R1 result", longint'(result), 0);
        rst_n = 1'b1;
        run_op(5, 0, 0);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule